// File: doc/BRIEF.md
# Selectable-Ratio Sinc-Cubed Interpolator

This block raises a stream of 16-bit two's complement samples from a host sample rate to a fixed high rate of one output every eight master clocks. The filter is a third-order cascaded integrator-comb with response ((1 - z^-N)/(1 - z^-1))^3. The ratio N can be set at run time to 32, 64, 128 or 256. Because the output rate is fixed, a larger ratio means a longer input period of 8*N master clocks.

The host writes a sample with a one-cycle valid strobe at any point in the input period. The block latches the most recent write. At the start of each input period the comb section takes the latched value. If no write arrived during the period, the previous value is used again. The integrators advance on every output tick, and the result is scaled back to unity DC gain and saturated to 16 bits.

A bypass input skips the filter for minimum delay. In bypass, each output strobe repeats the latched sample (zero-order hold). Changing the rate select clears the filter state and the tick counters.

Top module: `sinc3_interp`

## Requirements
- R1: `out_valid_o` is a single-cycle pulse. While `rate_sel_i` is unchanged, consecutive pulses are exactly 8 clocks apart for every rate setting.
- R2: `rate_sel_i` selects the ratio: 0 gives N=32, 1 gives N=64, 2 gives N=128, 3 gives N=256. With a constant latched input and bypass low, the output settles to exactly the input value within 5*N output strobes.
- R3: The full-scale values 0x7FFF (+32767) and 0x8000 (-32768) pass through at settled DC without wrap or loss.
- R4: When no new sample is written, the last latched sample is reused every input period, so the settled output stays constant.
- R5: After a step from zero to a positive constant, the output sequence never decreases and never exceeds the step value.
- R6: With `bypass_i` high, each strobe carries the most recent sample written before that strobe, with no filtering.
- R7: A change of `rate_sel_i` clears the filter state. With bypass low, the first strobe after the change carries 0.
- R8: After reset, `out_valid_o` is 0 and `out_data_o` is 0.
- R9: `out_data_o` changes only in cycles where `out_valid_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_data_i | input | 16 | Input sample, two's complement |
| in_valid_i | input | 1 | One-cycle write strobe for `in_data_i` |
| rate_sel_i | input | 2 | Ratio select: 0 gives N=32, 1 gives 64, 2 gives 128, 3 gives 256 |
| bypass_i | input | 1 | 1 selects zero-order hold with no filtering |
| out_data_o | output | 16 | Output sample, two's complement |
| out_valid_o | output | 1 | One-cycle strobe every 8 clocks |

## Verification
The bench settles DC values at every ratio, including both full-scale extremes. A wrong scale shift or a truncated accumulator would show up there as a gain error or a wrapped sign. It writes a single sample and then stops writing, so a design that fed zeros on missed writes would decay toward 0 instead of holding the value. After a rate change it checks that the first output is 0 and that the following step response rises monotonically to the target. Stale state left over from the old ratio would give a nonzero start or an overshoot. Bypass rows check that the held sample appears at once, which a design that still routed data through the filter would fail.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;
  localparam int DW      = 16;
  localparam int ORDER   = 3;
  localparam int CLK_PER = 8;
  localparam int LG_MIN  = 5;
  localparam int LG_MAX  = 8;
  localparam int RATE_W  = 2;
  localparam int AW      = DW + ORDER * LG_MAX;

  localparam logic signed [AW-1:0] MAX_V = AW'((2 ** (DW - 1)) - 1);
  localparam logic signed [AW-1:0] MIN_V = -MAX_V - AW'(1);

  function automatic logic [DW-1:0] sat16(input logic signed [AW-1:0] v);
    if (v > MAX_V)      return MAX_V[DW-1:0];
    else if (v < MIN_V) return MIN_V[DW-1:0];
    else                return v[DW-1:0];
  endfunction
endpackage

// File: rtl/sinc3_tick.sv
module sinc3_tick #(
  parameter int CLK_PER = 8,
  parameter int KW      = 8,
  parameter int LW      = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic [LW-1:0] lg_i,
  output logic          out_tick_o,
  output logic          in_tick_o
);
  localparam int PW = $clog2(CLK_PER);

  logic [PW-1:0] ph_q;
  logic [KW-1:0] k_q, k_max;

  assign k_max      = KW'((32'd1 << lg_i) - 32'd1);
  assign out_tick_o = !clr_i && (ph_q == PW'(CLK_PER - 1));
  assign in_tick_o  = out_tick_o && (k_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= '0;
      k_q  <= '0;
    end else if (clr_i) begin
      ph_q <= '0;
      k_q  <= '0;
    end else begin
      ph_q <= (ph_q == PW'(CLK_PER - 1)) ? '0 : ph_q + PW'(1);
      if (out_tick_o) k_q <= (k_q == k_max) ? '0 : k_q + KW'(1);
    end
  end
endmodule

// File: rtl/sinc3_comb.sv
module sinc3_comb #(
  parameter int AW    = 40,
  parameter int ORDER = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 en_i,
  input  logic signed [AW-1:0] x_i,
  output logic signed [AW-1:0] y_o
);
  logic signed [AW-1:0] c [ORDER+1];
  logic signed [AW-1:0] d_q [ORDER];

  assign c[0] = x_i;

  for (genvar s = 0; s < ORDER; s++) begin : g_stage
    assign c[s+1] = c[s] - d_q[s];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     d_q[s] <= '0;
      else if (clr_i)  d_q[s] <= '0;
      else if (en_i)   d_q[s] <= c[s];
    end
  end

  assign y_o = c[ORDER];
endmodule

// File: rtl/sinc3_integ.sv
module sinc3_integ #(
  parameter int AW    = 40,
  parameter int ORDER = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 en_i,
  input  logic signed [AW-1:0] u_i,
  output logic signed [AW-1:0] y_o
);
  logic signed [AW-1:0] acc_q [ORDER];
  logic signed [AW-1:0] feed [ORDER];

  for (genvar s = 0; s < ORDER; s++) begin : g_stage
    if (s == 0) begin : g_first
      assign feed[s] = u_i;
    end else begin : g_next
      assign feed[s] = acc_q[s-1];
    end
    // wrap-around is intended; width covers the true range
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     acc_q[s] <= '0;
      else if (clr_i)  acc_q[s] <= '0;
      else if (en_i)   acc_q[s] <= acc_q[s] + feed[s];
    end
  end

  assign y_o = acc_q[ORDER-1];
endmodule

// File: rtl/sinc3_interp.sv
module sinc3_interp
  import sinc3_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DW-1:0]     in_data_i,
  input  logic              in_valid_i,
  input  logic [RATE_W-1:0] rate_sel_i,
  input  logic              bypass_i,
  output logic [DW-1:0]     out_data_o,
  output logic              out_valid_o
);
  localparam int LW = 4;
  localparam int SW = 5;

  logic [DW-1:0]        hold_q;
  logic [RATE_W-1:0]    rate_q;
  logic                 clr;
  logic [LW-1:0]        lg;
  logic [SW-1:0]        shamt;
  logic                 out_tick, in_tick;
  logic signed [AW-1:0] x_ext, comb_y, integ_u, integ_y, scaled;
  logic [DW-1:0]        y_q;
  logic                 v_q;

  assign clr   = (rate_sel_i != rate_q);
  assign lg    = LW'(LG_MIN) + LW'(rate_sel_i);
  assign shamt = {lg, 1'b0};  // zero insertion loses N, so gain is N^2
  assign x_ext = {{(AW-DW){hold_q[DW-1]}}, hold_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      rate_q <= '0;
    end else begin
      rate_q <= rate_sel_i;
      if (in_valid_i) hold_q <= in_data_i;
    end
  end

  sinc3_tick #(.CLK_PER(CLK_PER), .KW(LG_MAX), .LW(LW)) u_tick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .lg_i      (lg),
    .out_tick_o(out_tick),
    .in_tick_o (in_tick)
  );

  sinc3_comb #(.AW(AW), .ORDER(ORDER)) u_comb (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .en_i  (in_tick),
    .x_i   (x_ext),
    .y_o   (comb_y)
  );

  assign integ_u = in_tick ? comb_y : '0;

  sinc3_integ #(.AW(AW), .ORDER(ORDER)) u_integ (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .en_i  (out_tick),
    .u_i   (integ_u),
    .y_o   (integ_y)
  );

  assign scaled = integ_y >>> shamt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_q <= '0;
      v_q <= 1'b0;
    end else begin
      v_q <= out_tick;
      if (out_tick) y_q <= bypass_i ? hold_q : sat16(scaled);
    end
  end

  assign out_data_o  = y_q;
  assign out_valid_o = v_q;
endmodule

// File: rtl/sinc3_interp_chk.sv
module sinc3_interp_chk
  import sinc3_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DW-1:0]     in_data_i,
  input logic              in_valid_i,
  input logic [RATE_W-1:0] rate_sel_i,
  input logic              bypass_i,
  input logic [DW-1:0]     out_data_o,
  input logic              out_valid_o
);
  logic [DW-1:0]     last_q;
  logic [RATE_W-1:0] rq;
  logic              chg_q;
  logic [7:0]        gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= '0;
      rq     <= '0;
      chg_q  <= 1'b0;
      gap_q  <= '0;
    end else begin
      rq <= rate_sel_i;
      if (in_valid_i) last_q <= in_data_i;
      if (rate_sel_i != rq) chg_q <= 1'b1;
      else if (out_valid_o) chg_q <= 1'b0;
      if (out_valid_o) gap_q <= 8'd1;
      else if (gap_q != '0 && gap_q != 8'hff) gap_q <= gap_q + 8'd1;
    end
  end

  p_pulse_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o);

  p_spacing_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && gap_q != '0 && !chg_q) |-> gap_q == 8'(CLK_PER));

  p_bypass_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && $past(bypass_i)) |-> out_data_o == $past(last_q));

  p_clear_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && chg_q && !$past(bypass_i)) |-> out_data_o == '0);

  p_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> $stable(out_data_o));
endmodule

bind sinc3_interp sinc3_interp_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_data_i  (in_data_i),
  .in_valid_i (in_valid_i),
  .rate_sel_i (rate_sel_i),
  .bypass_i   (bypass_i),
  .out_data_o (out_data_o),
  .out_valid_o(out_valid_o)
);

// File: tb/tb_sinc3_interp.sv
`timescale 1ns/1ps
module tb_sinc3_interp;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] in_data_i = '0;
  logic        in_valid_i = 1'b0;
  logic [1:0]  rate_sel_i = '0;
  logic        bypass_i = 1'b0;
  logic [15:0] out_data_o;
  logic        out_valid_o;

  int total = 0;
  int bad   = 0;

  always #2 clk_i = ~clk_i;

  sinc3_interp dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_data_i  (in_data_i),
    .in_valid_i (in_valid_i),
    .rate_sel_i (rate_sel_i),
    .bypass_i   (bypass_i),
    .out_data_o (out_data_o),
    .out_valid_o(out_valid_o)
  );

  // {rate, bypass, sample}; expected settled output equals sample
  localparam int NV = 9;
  localparam logic [18:0] VEC [NV] = '{
    {2'd0, 1'b0, 16'd1000},
    {2'd0, 1'b0, 16'hFC18},
    {2'd1, 1'b0, 16'd12345},
    {2'd2, 1'b0, 16'hB1E0},
    {2'd3, 1'b0, 16'h7FFF},
    {2'd3, 1'b0, 16'h8000},
    {2'd1, 1'b1, 16'd7},
    {2'd2, 1'b1, 16'hFFFB},
    {2'd0, 1'b0, 16'd0}
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic next_out(output int v);
    do begin
      @(posedge clk_i); #1;
    end while (!out_valid_o);
    v = int'($signed(out_data_o));
  endtask

  task automatic write_sample(input logic [15:0] v);
    in_data_i  = v;
    in_valid_i = 1'b1;
    @(posedge clk_i); #1;
    in_valid_i = 1'b0;
  endtask

  task automatic gap_check(input string req);
    int v, n;
    next_out(v);
    n = 0;
    do begin
      @(posedge clk_i); #1; n++;
      if (n == 1) check(req, int'(out_valid_o), 0);
    end while (!out_valid_o);
    check(req, n, 8);
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v, prev, n, exp_v;
    logic mono, cap, flat;
    repeat (3) @(posedge clk_i); #1;
    check("R8 valid", int'(out_valid_o), 0);
    check("R8 data", int'(out_data_o), 0);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;

    gap_check("R1 rate0");

    for (int i = 0; i < NV; i++) begin
      rate_sel_i = VEC[i][18:17];
      bypass_i   = VEC[i][16];
      @(posedge clk_i); #1;
      write_sample(VEC[i][15:0]);
      exp_v = int'($signed(VEC[i][15:0]));
      n = 5 * (32 << VEC[i][18:17]);
      repeat (n) next_out(v);
      for (int j = 0; j < 3; j++) begin
        next_out(v);
        if (VEC[i][16]) check("R6 bypass", v, exp_v);
        else if (exp_v == 32767 || exp_v == -32768) check("R3 full scale", v, exp_v);
        else check("R2 dc settle", v, exp_v);
      end
    end

    // new sample in bypass shows up on the second strobe at latest
    rate_sel_i = 2'd0; bypass_i = 1'b1;
    @(posedge clk_i); #1;
    write_sample(16'd4321);
    next_out(v); next_out(v);
    check("R6 bypass update", v, 4321);

    // rate change clears state; then step response 0 -> 500
    bypass_i = 1'b0;
    rate_sel_i = 2'd1;
    @(posedge clk_i); #1;
    write_sample(16'd500);
    repeat (5 * 64) next_out(v);
    rate_sel_i = 2'd2;
    next_out(v);
    check("R7 clear zero", v, 0);
    prev = v; mono = 1'b1; cap = 1'b1;
    for (int j = 0; j < 5 * 128; j++) begin
      next_out(v);
      if (v < prev) mono = 1'b0;
      if (v > 500) cap = 1'b0;
      prev = v;
    end
    check("R5 monotonic", int'(mono), 1);
    check("R5 no overshoot", int'(cap), 1);
    check("R5 final", v, 500);

    // no further writes: output must hold
    flat = 1'b1;
    for (int j = 0; j < 2 * 128; j++) begin
      next_out(v);
      if (v != 500) flat = 1'b0;
    end
    check("R4 reuse", int'(flat), 1);
    check("R4 last", v, 500);

    rate_sel_i = 2'd3;
    @(posedge clk_i); #1;
    gap_check("R1 rate3");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule